// File: doc/BRIEF.md
# Flyback Sample Trigger Timing Generator

This block produces the sampling strobes for a primary-side regulated flyback controller. It watches the gate-drive PWM and the peak-current comparator, both asynchronous to the system clock, and measures every conduction interval in clock ticks. It uses the length measured in the previous switching cycle to place one strobe at the middle of the present on-time. That single strobe serves both the line-voltage sample and the switch-current sample, so the current reading is the on-time average.

Conduction is taken to end when the comparator reports that the switch current has reached its demanded peak. If the PWM drops first, for example at a duty limit, the PWM falling edge ends conduction instead. A programmable number of ticks after that instant, once leakage ringing has settled, the block issues the output-voltage strobe. The sample point is fixed relative to turn-off rather than found at a knee, so it keeps working when secondary current is still flowing. This allows continuous conduction. If the next switching cycle starts before the delay runs out, the output strobe is dropped and a missed-sample pulse is raised.

Top module: `fb_sample_timer`

## Requirements
- R1: With the PWM input high for H clock cycles and no comparator trip, `ton_o` reads H (saturating at 2^CNT_W-1) from the third cycle after the PWM input falls. `ton_o` changes only when conduction ends.
- R2: When the comparator input rises T cycles after the PWM input rises (T < H), conduction ends there and `ton_o` reads T. A later PWM fall in the same switching cycle creates no second end event.
- R3: The on-time count saturates at 2^CNT_W-1 and never wraps.
- R4: `vin_strobe_o` pulses in the cycle 4+M clock edges after the PWM input rises, where M = floor(previous `ton_o` / 2). After reset the previous value is 0.
- R5: `vin_strobe_o` fires at most once per on-time and only while conducting. If conduction ends before the count reaches M, it does not fire at all.
- R6: `vo_strobe_o` pulses once, 4+D clock edges after the input change that ends conduction, where D is the value on `vo_dly_i`.
- R7: Because the output strobe is timed from the comparator trip, it may fire while the PWM input is still high, and the later PWM fall adds nothing.
- R8: If the PWM input rises again before the delay expires, no output strobe is produced for that cycle. `vo_miss_o` pulses one cycle, 3 edges after that rise.
- R9: `vo_dly_i` is captured at the end of conduction. Changing it while a delay is running has no effect on that strobe.
- R10: After reset all strobes, `vo_miss_o` and `ton_o` are 0. Every strobe and flag is one clock cycle wide. Both asynchronous inputs pass two synchronizer flops before any edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Gate-drive PWM, asynchronous |
| ipk_trip_i | input | 1 | Peak-current comparator output, asynchronous, high once current reaches the demand |
| vo_dly_i | input | DLY_W | Output-sample delay after conduction end, in ticks |
| vin_strobe_o | output | 1 | Mid-on-time strobe for line voltage and switch current |
| vo_strobe_o | output | 1 | Output-voltage sample strobe |
| vo_miss_o | output | 1 | Output sample skipped because a new cycle began |
| ton_o | output | CNT_W | Last measured on-time in ticks |

## Verification
The hardest situation to reach from the ports is a switching cycle whose off-time is shorter than the programmed output delay. In that case the next turn-on must land while the delay counter is still running. The bench builds it by raising the delay register and then issuing a short on/off pair immediately followed by a new on-time. It then confirms that no output strobe appeared, that the miss pulse sits at the fixed latency after the new rise, and that the following cycle behaves normally. A second awkward case is the midpoint landing past the end of a shrinking on-time. The bench reaches it by following a long cycle with a much shorter one.

// File: rtl/fbst_pkg.sv
package fbst_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction
endpackage

// File: rtl/fbst_sync.sv
module fbst_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  import fbst_pkg::*;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [SYNC_STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[SYNC_STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/fbst_ontime.sv
module fbst_ontime #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             pwm_s_i,
  input  logic             trip_s_i,
  output logic             on_o,
  output logic             eoc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ton_o,
  output logic             vin_stb_o
);
  import fbst_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             on_q, vin_q;
  logic [CNT_W-1:0] cnt_q, ton_q, cnt_inc, mid;
  logic             eoc;

  // conduction ends at comparator trip, or at PWM fall if that comes first
  assign eoc     = on_q & (trip_s_i | ~pwm_s_i);
  assign cnt_inc = CNT_W'(sat_inc(32'(cnt_q), 32'(CNT_MAX)));
  assign mid     = ton_q >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
      ton_q <= '0;
      vin_q <= 1'b0;
    end else begin
      vin_q <= on_q & ~eoc & (cnt_q == mid);
      if (rise_i) begin
        on_q  <= 1'b1;
        cnt_q <= '0;
      end else if (eoc) begin
        on_q  <= 1'b0;
        ton_q <= cnt_inc;
      end else if (on_q) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign on_o      = on_q;
  assign eoc_o     = eoc;
  assign cnt_o     = cnt_q;
  assign ton_o     = ton_q;
  assign vin_stb_o = vin_q;
endmodule

// File: rtl/fbst_vodelay.sv
module fbst_vodelay #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eoc_i,
  input  logic             rise_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             vo_stb_o,
  output logic             miss_o
);
  logic             armed_q, stb_q, miss_q;
  logic [DLY_W-1:0] dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      dcnt_q  <= '0;
      stb_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      stb_q  <= 1'b0;
      miss_q <= 1'b0;
      if (eoc_i) begin
        armed_q <= 1'b1;
        dcnt_q  <= dly_i;
      end else if (armed_q) begin
        if (rise_i) begin
          armed_q <= 1'b0;
          miss_q  <= 1'b1;
        end else if (dcnt_q == '0) begin
          armed_q <= 1'b0;
          stb_q   <= 1'b1;
        end else begin
          dcnt_q <= dcnt_q - 1'b1;
        end
      end
    end
  end

  assign vo_stb_o = stb_q;
  assign miss_o   = miss_q;
endmodule

// File: rtl/fb_sample_timer.sv
module fb_sample_timer #(
  parameter int CNT_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             ipk_trip_i,
  input  logic [DLY_W-1:0] vo_dly_i,
  output logic             vin_strobe_o,
  output logic             vo_strobe_o,
  output logic             vo_miss_o,
  output logic [CNT_W-1:0] ton_o
);
  logic [1:0]       sync_q;
  logic             pwm_s, trip_s, pwm_d, rise;
  logic             on_w, eoc_w;
  logic [CNT_W-1:0] cnt_w;

  fbst_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ipk_trip_i, pwm_i}),
    .q_o   (sync_q)
  );
  assign pwm_s  = sync_q[0];
  assign trip_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_d <= 1'b0;
    else         pwm_d <= pwm_s;
  end
  assign rise = pwm_s & ~pwm_d;

  fbst_ontime #(.CNT_W(CNT_W)) u_ontime (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .pwm_s_i  (pwm_s),
    .trip_s_i (trip_s),
    .on_o     (on_w),
    .eoc_o    (eoc_w),
    .cnt_o    (cnt_w),
    .ton_o    (ton_o),
    .vin_stb_o(vin_strobe_o)
  );

  fbst_vodelay #(.DLY_W(DLY_W)) u_vodelay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eoc_i   (eoc_w),
    .rise_i  (rise),
    .dly_i   (vo_dly_i),
    .vo_stb_o(vo_strobe_o),
    .miss_o  (vo_miss_o)
  );
endmodule

// File: rtl/fb_sample_timer_chk.sv
module fb_sample_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             on_w,
  input logic             eoc_w,
  input logic             rise,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] ton_o,
  input logic             vin_strobe_o,
  input logic             vo_strobe_o,
  input logic             vo_miss_o
);
  a_r5_vin_while_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vin_strobe_o |-> on_w);
  a_r7_vo_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vo_strobe_o |-> !on_w);
  a_r8_miss_at_turn_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vo_miss_o |-> (on_w && !vo_strobe_o));
  a_r10_vin_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vin_strobe_o |=> !vin_strobe_o);
  a_r10_vo_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vo_strobe_o |=> !vo_strobe_o);
  a_r1_ton_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(eoc_w) |-> $stable(ton_o));
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_w && $past(on_w) && !$past(rise)) |-> (cnt_w >= $past(cnt_w)));
endmodule

bind fb_sample_timer fb_sample_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .on_w        (on_w),
  .eoc_w       (eoc_w),
  .rise        (rise),
  .cnt_w       (cnt_w),
  .ton_o       (ton_o),
  .vin_strobe_o(vin_strobe_o),
  .vo_strobe_o (vo_strobe_o),
  .vo_miss_o   (vo_miss_o)
);

// File: tb/fb_sample_timer_bench.sv
`timescale 1ns/1ps
module fb_sample_timer_bench;
  localparam int CNT_W = 8;
  localparam int DLY_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pwm_i = 1'b0;
  logic             ipk_trip_i = 1'b0;
  logic [DLY_W-1:0] vo_dly_i = '0;
  logic             vin_strobe_o, vo_strobe_o, vo_miss_o;
  logic [CNT_W-1:0] ton_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  fb_sample_timer #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_fb_sample_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .ipk_trip_i(ipk_trip_i),
    .vo_dly_i(vo_dly_i), .vin_strobe_o(vin_strobe_o), .vo_strobe_o(vo_strobe_o),
    .vo_miss_o(vo_miss_o), .ton_o(ton_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // ticks counted from the negedge that drives pwm_i high
  task automatic pulse(input int on_len, input int trip_at, input int off_len,
                       input int chg_at, input int chg_val,
                       output int vin_at, output int vo_at, output int miss_at,
                       output int vin_n, output int vo_n);
    vin_at = -1; vo_at = -1; miss_at = -1; vin_n = 0; vo_n = 0;
    pwm_i = 1'b1;
    for (int t = 1; t <= on_len + off_len; t++) begin
      tick();
      if (vin_strobe_o) begin vin_n++; if (vin_at < 0) vin_at = t; end
      if (vo_strobe_o)  begin vo_n++;  if (vo_at < 0)  vo_at = t;  end
      if (vo_miss_o && miss_at < 0) miss_at = t;
      if (t == trip_at) ipk_trip_i = 1'b1;
      if (t == chg_at) vo_dly_i = DLY_W'(chg_val);
      if (t == on_len) begin pwm_i = 1'b0; ipk_trip_i = 1'b0; end
    end
  endtask

  int va, oa, ma, vn, on_n;

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) tick();
    chk(vin_strobe_o == 0 && vo_strobe_o == 0 && vo_miss_o == 0, "R10 reset strobes", 0, 0);
    chk(ton_o == 0, "R10 reset ton", int'(ton_o), 0);
    rst_ni = 1'b1;
    repeat (2) tick();
  endtask

  task automatic t_first();
    vo_dly_i = 8'd3;
    pulse(10, 0, 20, 0, 0, va, oa, ma, vn, on_n);
    chk(va == 4, "R4 vin after reset", va, 4);
    chk(vn == 1, "R10 vin single", vn, 1);
    chk(ton_o == 10, "R1 ton pwm end", int'(ton_o), 10);
    chk(oa == 17, "R6 vo delay", oa, 17);
    chk(on_n == 1, "R10 vo single", on_n, 1);
  endtask

  task automatic t_adapt();
    pulse(20, 0, 30, 0, 0, va, oa, ma, vn, on_n);
    chk(va == 9, "R4 mid of prev 10", va, 9);
    chk(ton_o == 20, "R1 ton 20", int'(ton_o), 20);
    chk(oa == 27, "R6 vo after 20", oa, 27);
    pulse(6, 0, 20, 0, 0, va, oa, ma, vn, on_n);
    chk(vn == 0, "R5 vin past end suppressed", vn, 0);
    chk(ton_o == 6, "R1 ton 6", int'(ton_o), 6);
    pulse(10, 0, 20, 0, 0, va, oa, ma, vn, on_n);
    chk(va == 7, "R4 mid of prev 6", va, 7);
  endtask

  task automatic t_trip();
    pulse(30, 12, 30, 0, 0, va, oa, ma, vn, on_n);
    chk(va == 9, "R4 mid before trip", va, 9);
    chk(ton_o == 12, "R2 ton from trip", int'(ton_o), 12);
    chk(oa == 19, "R7 vo from trip while pwm high", oa, 19);
    chk(on_n == 1, "R2 no second end at pwm fall", on_n, 1);
  endtask

  task automatic t_dly_change();
    vo_dly_i = 8'd5;
    pulse(10, 0, 25, 14, 1, va, oa, ma, vn, on_n);
    chk(va == 10, "R4 mid of prev 12", va, 10);
    chk(oa == 19, "R9 delay captured at end", oa, 19);
  endtask

  task automatic t_miss();
    vo_dly_i = 8'd10;
    pulse(8, 0, 5, 0, 0, va, oa, ma, vn, on_n);
    chk(on_n == 0, "R8 no vo when cut short", on_n, 0);
    chk(ton_o == 8, "R1 ton 8", int'(ton_o), 8);
    pulse(8, 0, 30, 0, 0, va, oa, ma, vn, on_n);
    chk(ma == 3, "R8 miss pulse", ma, 3);
    chk(oa == 22, "R8 next cycle vo", oa, 22);
    chk(va == 8, "R4 mid in short off", va, 8);
  endtask

  task automatic t_sat();
    vo_dly_i = 8'd2;
    pulse(300, 0, 20, 0, 0, va, oa, ma, vn, on_n);
    chk(ton_o == 255, "R3 saturate", int'(ton_o), 255);
    chk(oa == 306, "R6 vo after long on", oa, 306);
    pulse(300, 0, 20, 0, 0, va, oa, ma, vn, on_n);
    chk(va == 131, "R3 mid of saturated", va, 131);
    chk(vn == 1, "R5 vin once while saturated", vn, 1);
  endtask

  initial begin
    t_reset();
    t_first();
    t_adapt();
    t_trip();
    t_dly_change();
    t_miss();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule